// File: doc/BRIEF.md
# Reference clock supervisor and selector

This block watches two reference clocks, both sampled by a faster local system clock. Each input passes through a set of detectors. The interval detector flags late edges (missing pulses) and early edges. The runt detector flags high phases that are too short. The frequency detector counts edges over a fixed gate window. For pulse-per-second references, a 1PPS mode swaps in a separate, much wider pair of interval limits. Every detector has its own limit and its own enable per input. Any enabled violation puts that input into loss-of-reference (LOR). An input leaves LOR only after a programmed number of clean gate windows in a row.

A selector picks the active reference from the LOR flags. In automatic mode it uses a programmable preferred input and returns to it once that input qualifies again. In manual mode the choice comes from a register field or from a select pin. If the chosen input is in LOR, the lowest-index valid input is used instead. When every input is in LOR, a holdover request is raised and the selected index keeps its last value. Each change of the selected index, and each entry into or exit from holdover, gives a one-cycle interrupt pulse and sets a sticky flag. The sticky flags are cleared by a register write strobe.

All pins are plain control and status signals. There is no data stream, so no valid/ready handshake exists.

Top module: `refmon_top`

## Requirements
- R1: During and right after reset, every input is in LOR, holdover is 1, the selected index is 0, and irq and both sticky flags are 0.
- R2: With the missing detector enabled (enable bit 1), an input whose time since its last rising edge exceeds the late limit (in system-clock cycles) enters LOR.
- R3: With the early detector enabled (bit 2), a rising edge that comes fewer than early-limit cycles after the previous rising edge puts the input into LOR.
- R4: With the runt detector enabled (bit 3), a high phase shorter than the runt minimum (in cycles) puts the input into LOR.
- R5: With the frequency detector enabled (bit 0), a gate window whose rising-edge count is below the minimum or above the maximum puts the input into LOR.
- R6: A detector whose enable bit is 0 has no effect. With all enable bits of an input at 0, a stopped clock leaves that input out of LOR.
- R7: When 1PPS mode is set (bit 4), the late and early checks always apply and use the 1PPS limits, and the frequency detector is not applied. A 200-cycle period that fails the normal limits is then accepted, and a stopped input still enters LOR.
- R8: An input leaves LOR only after clean-count consecutive gate windows with no violation, so it is still in LOR one short window after its clock returns.
- R9: In automatic mode (man_en=0), the preferred input cfg_prio is selected whenever it is not in LOR. Otherwise the lowest-index valid input is selected, and the preferred input is selected again once it requalifies.
- R10: In manual mode (man_en=1), the choice is man_pin_sel when man_use_pin=1 and man_reg_sel otherwise. If the chosen input is in LOR, another valid input is selected.
- R11: holdover is 1 exactly when every input is in LOR, and while it is 1 sel_idx keeps its previous value.
- R12: Each change of sel_idx or holdover gives irq for exactly one cycle and sets sticky_sel_chg or sticky_ho_chg respectively. A sticky_clr pulse clears both flags unless a new event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NREF | Asynchronous reference clock inputs |
| cfg_det_en | input | NREF x 5 | Per-input enables: 0 freq, 1 missing, 2 early, 3 runt, 4 1PPS mode |
| cfg_early_lim | input | NREF x CNT_W | Minimum edge interval, in cycles |
| cfg_late_lim | input | NREF x CNT_W | Maximum edge interval, in cycles |
| cfg_runt_min | input | NREF x CNT_W | Minimum high time, in cycles |
| cfg_pps_early | input | NREF x CNT_W | Minimum interval in 1PPS mode |
| cfg_pps_late | input | NREF x CNT_W | Maximum interval in 1PPS mode |
| cfg_freq_min | input | NREF x EDGE_W | Minimum edges per gate window |
| cfg_freq_max | input | NREF x EDGE_W | Maximum edges per gate window |
| cfg_clean_need | input | NREF x CLEAN_W | Clean windows needed to leave LOR |
| cfg_prio | input | SEL_W | Preferred input in automatic mode |
| man_en | input | 1 | 1 selects manual mode |
| man_use_pin | input | 1 | Manual source: 1 pin, 0 register |
| man_reg_sel | input | SEL_W | Manual choice from the register |
| man_pin_sel | input | SEL_W | Manual choice from the select pin |
| sticky_clr | input | 1 | Register write strobe that clears the sticky flags |
| sel_idx | output | SEL_W | Selected input index |
| holdover | output | 1 | Holdover request |
| lor_status | output | NREF | Per-input loss-of-reference flags |
| irq | output | 1 | One-cycle event pulse |
| sticky_sel_chg | output | 1 | Sticky flag: selection changed |
| sticky_ho_chg | output | 1 | Sticky flag: holdover entered or left |

## Verification
The bench builds the block with GATE_CYC set to 64 and keeps the other defaults (two inputs, 12-bit interval counters, 4-bit clean count). The short gate window lets an input requalify after two clean windows within about two hundred cycles. That puts revertive switching, manual fallback and holdover entry and exit within a short run. The 12-bit interval counters leave room for a 200-cycle 1PPS period next to an 8-cycle normal period.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
  localparam int DET_FREQ  = 0;
  localparam int DET_MISS  = 1;
  localparam int DET_EARLY = 2;
  localparam int DET_RUNT  = 3;
  localparam int DET_PPS   = 4;
  localparam int DET_W     = 5;
endpackage

// File: rtl/refmon_chan.sv
module refmon_chan
  import refmon_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int EDGE_W   = 12,
  parameter int GATE_CYC = 1024,
  parameter int CLEAN_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_in,
  input  logic [DET_W-1:0]   det_en,
  input  logic [CNT_W-1:0]   early_lim,
  input  logic [CNT_W-1:0]   late_lim,
  input  logic [CNT_W-1:0]   runt_min,
  input  logic [CNT_W-1:0]   pps_early,
  input  logic [CNT_W-1:0]   pps_late,
  input  logic [EDGE_W-1:0]  freq_min,
  input  logic [EDGE_W-1:0]  freq_max,
  input  logic [CLEAN_W-1:0] clean_need,
  output logic               lor
);
  localparam int GW = (GATE_CYC > 1) ? $clog2(GATE_CYC) : 1;

  logic [2:0]         sh;
  logic               rise, fall, armed;
  logic [CNT_W-1:0]   per_cnt, hi_cnt, e_lim, l_lim;
  logic [GW-1:0]      gate_cnt;
  logic [EDGE_W-1:0]  edge_cnt, edge_tot;
  logic [CLEAN_W-1:0] clean_cnt;
  logic               pps, e_on, m_on, f_on, win_end, bad_win;
  logic               v_early, v_miss, v_runt, v_freq, viol;

  // two-stage synchronizer plus one history stage
  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], ref_in};
  end
  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];

  assign pps   = det_en[DET_PPS];
  assign e_on  = pps | det_en[DET_EARLY];
  assign m_on  = pps | det_en[DET_MISS];
  assign f_on  = ~pps & det_en[DET_FREQ];
  assign e_lim = pps ? pps_early : early_lim;
  assign l_lim = pps ? pps_late  : late_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      hi_cnt  <= '0;
      armed   <= 1'b0;
    end else begin
      if (rise) begin
        per_cnt <= CNT_W'(1);
        hi_cnt  <= CNT_W'(1);
        armed   <= 1'b1;
      end else begin
        if (per_cnt != '1)           per_cnt <= per_cnt + 1'b1;
        if (sh[1] && hi_cnt != '1)   hi_cnt  <= hi_cnt + 1'b1;
      end
    end
  end

  assign win_end  = (gate_cnt == GW'(GATE_CYC - 1));
  assign edge_tot = edge_cnt + EDGE_W'(rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_cnt <= '0;
      edge_cnt <= '0;
    end else if (win_end) begin
      gate_cnt <= '0;
      edge_cnt <= '0;
    end else begin
      gate_cnt <= gate_cnt + 1'b1;
      if (rise && edge_cnt != '1) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assign v_early = e_on & rise & armed & (per_cnt < e_lim);
  assign v_miss  = m_on & (per_cnt > l_lim);
  assign v_runt  = det_en[DET_RUNT] & fall & armed & (hi_cnt < runt_min);
  assign v_freq  = f_on & win_end & ((edge_tot < freq_min) | (edge_tot > freq_max));
  assign viol    = v_early | v_miss | v_runt | v_freq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lor       <= 1'b1;
      clean_cnt <= '0;
      bad_win   <= 1'b0;
    end else begin
      bad_win <= win_end ? 1'b0 : (bad_win | viol);
      if (viol) begin
        lor       <= 1'b1;
        clean_cnt <= '0;
      end else if (win_end) begin
        if (bad_win) begin
          clean_cnt <= '0;
        end else if (lor) begin
          if (({1'b0, clean_cnt} + 1'b1) >= {1'b0, clean_need}) begin
            lor       <= 1'b0;
            clean_cnt <= '0;
          end else begin
            clean_cnt <= clean_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/refmon_sel.sv
module refmon_sel #(
  parameter int NREF  = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREF-1:0]  lor,
  input  logic [SEL_W-1:0] cfg_prio,
  input  logic             man_en,
  input  logic             man_use_pin,
  input  logic [SEL_W-1:0] man_reg_sel,
  input  logic [SEL_W-1:0] man_pin_sel,
  input  logic             sticky_clr,
  output logic [SEL_W-1:0] sel_idx,
  output logic             holdover,
  output logic             irq,
  output logic             sticky_sel_chg,
  output logic             sticky_ho_chg
);
  logic [SEL_W-1:0] want, fallback, choice, nxt_sel;
  logic             want_ok, nxt_ho, sel_chg, ho_chg;

  always_comb begin
    want = man_en ? (man_use_pin ? man_pin_sel : man_reg_sel) : cfg_prio;
    want_ok = 1'b0;
    if (int'(want) < NREF) want_ok = ~lor[want];
    fallback = sel_idx;
    for (int i = NREF - 1; i >= 0; i--) begin
      if (!lor[i]) fallback = SEL_W'(i);
    end
    choice  = want_ok ? want : fallback;
    nxt_ho  = &lor;
    nxt_sel = nxt_ho ? sel_idx : choice;
    sel_chg = (nxt_sel != sel_idx);
    ho_chg  = (nxt_ho != holdover);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx        <= '0;
      holdover       <= 1'b1;
      irq            <= 1'b0;
      sticky_sel_chg <= 1'b0;
      sticky_ho_chg  <= 1'b0;
    end else begin
      sel_idx        <= nxt_sel;
      holdover       <= nxt_ho;
      irq            <= sel_chg | ho_chg;
      sticky_sel_chg <= sel_chg | (sticky_sel_chg & ~sticky_clr);
      sticky_ho_chg  <= ho_chg  | (sticky_ho_chg  & ~sticky_clr);
    end
  end
endmodule

// File: rtl/refmon_top.sv
module refmon_top
  import refmon_pkg::*;
#(
  parameter int NREF     = 2,
  parameter int CNT_W    = 12,
  parameter int GATE_CYC = 1024,
  parameter int CLEAN_W  = 4,
  localparam int EDGE_W  = $clog2(GATE_CYC + 1) + 1,
  localparam int SEL_W   = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NREF-1:0]                ref_in,
  input  logic [NREF-1:0][DET_W-1:0]     cfg_det_en,
  input  logic [NREF-1:0][CNT_W-1:0]     cfg_early_lim,
  input  logic [NREF-1:0][CNT_W-1:0]     cfg_late_lim,
  input  logic [NREF-1:0][CNT_W-1:0]     cfg_runt_min,
  input  logic [NREF-1:0][CNT_W-1:0]     cfg_pps_early,
  input  logic [NREF-1:0][CNT_W-1:0]     cfg_pps_late,
  input  logic [NREF-1:0][EDGE_W-1:0]    cfg_freq_min,
  input  logic [NREF-1:0][EDGE_W-1:0]    cfg_freq_max,
  input  logic [NREF-1:0][CLEAN_W-1:0]   cfg_clean_need,
  input  logic [SEL_W-1:0]               cfg_prio,
  input  logic                           man_en,
  input  logic                           man_use_pin,
  input  logic [SEL_W-1:0]               man_reg_sel,
  input  logic [SEL_W-1:0]               man_pin_sel,
  input  logic                           sticky_clr,
  output logic [SEL_W-1:0]               sel_idx,
  output logic                           holdover,
  output logic [NREF-1:0]                lor_status,
  output logic                           irq,
  output logic                           sticky_sel_chg,
  output logic                           sticky_ho_chg
);
  for (genvar g = 0; g < NREF; g++) begin : g_chan
    refmon_chan #(
      .CNT_W(CNT_W), .EDGE_W(EDGE_W), .GATE_CYC(GATE_CYC), .CLEAN_W(CLEAN_W)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_in     (ref_in[g]),
      .det_en     (cfg_det_en[g]),
      .early_lim  (cfg_early_lim[g]),
      .late_lim   (cfg_late_lim[g]),
      .runt_min   (cfg_runt_min[g]),
      .pps_early  (cfg_pps_early[g]),
      .pps_late   (cfg_pps_late[g]),
      .freq_min   (cfg_freq_min[g]),
      .freq_max   (cfg_freq_max[g]),
      .clean_need (cfg_clean_need[g]),
      .lor        (lor_status[g])
    );
  end

  refmon_sel #(.NREF(NREF), .SEL_W(SEL_W)) u_sel (
    .clk            (clk),
    .rst_n          (rst_n),
    .lor            (lor_status),
    .cfg_prio       (cfg_prio),
    .man_en         (man_en),
    .man_use_pin    (man_use_pin),
    .man_reg_sel    (man_reg_sel),
    .man_pin_sel    (man_pin_sel),
    .sticky_clr     (sticky_clr),
    .sel_idx        (sel_idx),
    .holdover       (holdover),
    .irq            (irq),
    .sticky_sel_chg (sticky_sel_chg),
    .sticky_ho_chg  (sticky_ho_chg)
  );
endmodule

// File: rtl/refmon_chk.sv
module refmon_chk #(
  parameter int NREF  = 2,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREF-1:0]  lor_status,
  input logic [SEL_W-1:0] sel_idx,
  input logic             holdover,
  input logic             irq,
  input logic             sticky_sel_chg,
  input logic             sticky_ho_chg,
  input logic             sticky_clr,
  input logic [SEL_W-1:0] cfg_prio,
  input logic             man_en
);
  logic [NREF-1:0]  lor_d;
  logic [SEL_W-1:0] prio_d;
  logic             man_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lor_d  <= '1;
      prio_d <= '0;
      man_d  <= 1'b0;
    end else begin
      lor_d  <= lor_status;
      prio_d <= cfg_prio;
      man_d  <= man_en;
    end
  end

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((sel_idx != $past(sel_idx)) || (holdover != $past(holdover)))); // R12

  AST_HOLDOVER_ALL_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    holdover == (&lor_d)); // R11

  AST_SEL_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !holdover |-> !lor_d[sel_idx]); // R10

  AST_AUTO_PREFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_d && !lor_d[prio_d]) |-> (sel_idx == prio_d)); // R9

  AST_STICKY_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sticky_sel_chg || sticky_ho_chg)); // R12

  AST_STICKY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sticky_clr) && !irq) |-> (!sticky_sel_chg && !sticky_ho_chg)); // R12
endmodule

bind refmon_top refmon_chk #(.NREF(NREF), .SEL_W(SEL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lor_status     (lor_status),
  .sel_idx        (sel_idx),
  .holdover       (holdover),
  .irq            (irq),
  .sticky_sel_chg (sticky_sel_chg),
  .sticky_ho_chg  (sticky_ho_chg),
  .sticky_clr     (sticky_clr),
  .cfg_prio       (cfg_prio),
  .man_en         (man_en)
);

// File: tb/sim_refmon_top.sv
module sim_refmon_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREF = 2;
  localparam int CNT_W = 12;
  localparam int GATE = 64;
  localparam int EDGE_W = $clog2(GATE + 1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREF-1:0] ref_in;
  logic [NREF-1:0][4:0] det_en;
  logic [NREF-1:0][CNT_W-1:0] early_lim, late_lim, runt_min, pps_early, pps_late;
  logic [NREF-1:0][EDGE_W-1:0] fmin, fmax;
  logic [NREF-1:0][3:0] clean_need;
  logic cfg_prio, man_en, man_use_pin, man_reg_sel, man_pin_sel, sticky_clr;
  logic sel_idx, holdover, irq, st_sel, st_ho;
  logic [NREF-1:0] lor;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  logic run0 = 1'b0, run1 = 1'b0;
  int hi0 = 4, lo0 = 4, hi1 = 4, lo1 = 4;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refmon_top #(.NREF(NREF), .CNT_W(CNT_W), .GATE_CYC(GATE), .CLEAN_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .cfg_det_en(det_en),
    .cfg_early_lim(early_lim), .cfg_late_lim(late_lim), .cfg_runt_min(runt_min),
    .cfg_pps_early(pps_early), .cfg_pps_late(pps_late),
    .cfg_freq_min(fmin), .cfg_freq_max(fmax), .cfg_clean_need(clean_need),
    .cfg_prio(cfg_prio), .man_en(man_en), .man_use_pin(man_use_pin),
    .man_reg_sel(man_reg_sel), .man_pin_sel(man_pin_sel), .sticky_clr(sticky_clr),
    .sel_idx(sel_idx), .holdover(holdover), .lor_status(lor), .irq(irq),
    .sticky_sel_chg(st_sel), .sticky_ho_chg(st_ho));

  initial begin
    ref_in[0] = 1'b0;
    forever begin
      if (run0) begin
        @(negedge clk) ref_in[0] = 1'b1;
        repeat (hi0) @(negedge clk);
        ref_in[0] = 1'b0;
        repeat (lo0 - 1) @(negedge clk);
      end else begin
        ref_in[0] = 1'b0;
        @(negedge clk);
      end
    end
  end

  initial begin
    ref_in[1] = 1'b0;
    forever begin
      if (run1) begin
        @(negedge clk) ref_in[1] = 1'b1;
        repeat (hi1) @(negedge clk);
        ref_in[1] = 1'b0;
        repeat (lo1 - 1) @(negedge clk);
      end else begin
        ref_in[1] = 1'b0;
        @(negedge clk);
      end
    end
  end

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic defaults(input int i);
    det_en[i] = 5'b01111; early_lim[i] = 5; late_lim[i] = 12; runt_min[i] = 2;
    pps_early[i] = 150; pps_late[i] = 260; fmin[i] = 6; fmax[i] = 10; clean_need[i] = 2;
  endtask

  task automatic t_reset;
    wcyc(3);
    chk("R1 lor", lor, 3); chk("R1 holdover", holdover, 1); chk("R1 sel", sel_idx, 0);
    chk("R1 irq", irq, 0); chk("R1 sticky", {st_sel, st_ho}, 0);
    rst_n = 1'b1; run0 = 1'b1; run1 = 1'b1;
    wcyc(1);
    chk("R1 lor after release", lor, 3);
  endtask

  task automatic t_qualify;
    wcyc(60);
    chk("R8 lor before clean windows", lor, 3);
    wcyc(340);
    chk("R9 lor qualified", lor, 0); chk("R11 holdover exit", holdover, 0);
    chk("R9 sel preferred", sel_idx, 0); chk("R12 sticky_ho", st_ho, 1);
  endtask

  task automatic t_missing;
    int base;
    base = irq_cnt;
    run0 = 1'b0; wcyc(40);
    chk("R2 lor0 missing", lor[0], 1); chk("R9 sel fallback", sel_idx, 1);
    chk("R12 one irq on switch", irq_cnt - base, 1); chk("R12 sticky_sel", st_sel, 1);
    run0 = 1'b1; wcyc(60);
    chk("R8 lor0 held after restart", lor[0], 1);
    wcyc(300);
    chk("R8 lor0 requalified", lor[0], 0); chk("R9 revert", sel_idx, 0);
    chk("R12 two irqs", irq_cnt - base, 2);
  endtask

  task automatic t_early;
    det_en[0] = 5'b01110; hi0 = 2; lo0 = 2; wcyc(40);
    chk("R3 lor0 early", lor[0], 1);
    hi0 = 4; lo0 = 4; wcyc(300);
    chk("R3 lor0 recovered", lor[0], 0);
    defaults(0); wcyc(200);
  endtask

  task automatic t_runt;
    int base;
    base = irq_cnt;
    hi1 = 1; lo1 = 7; wcyc(40);
    chk("R4 lor1 runt", lor[1], 1); chk("R9 sel stays preferred", sel_idx, 0);
    chk("R12 no irq", irq_cnt - base, 0);
    hi1 = 4; lo1 = 4; wcyc(300);
    chk("R4 lor1 recovered", lor[1], 0);
  endtask

  task automatic t_freq;
    det_en[0] = 5'b01001; hi0 = 8; lo0 = 8; wcyc(150);
    chk("R5 lor0 slow", lor[0], 1);
    hi0 = 4; lo0 = 4; wcyc(300);
    chk("R5 lor0 nominal", lor[0], 0);
    hi0 = 2; lo0 = 2; wcyc(150);
    chk("R5 lor0 fast", lor[0], 1);
    hi0 = 4; lo0 = 4; wcyc(300);
    chk("R5 lor0 recovered", lor[0], 0);
    defaults(0); wcyc(200);
  endtask

  task automatic t_disabled;
    det_en[0] = 5'b00000; run0 = 1'b0; wcyc(300);
    chk("R6 lor0 unaffected", lor[0], 0); chk("R6 sel unaffected", sel_idx, 0);
    run0 = 1'b1; defaults(0); wcyc(400);
    chk("R6 lor0 after re-enable", lor[0], 0);
  endtask

  task automatic t_pps;
    det_en[1] = 5'b11000; hi1 = 20; lo1 = 180; wcyc(1200);
    chk("R7 pps accepted", lor[1], 0);
    det_en[1] = 5'b01111; wcyc(50);
    chk("R7 normal limits reject", lor[1], 1);
    det_en[1] = 5'b11000; wcyc(1200);
    chk("R7 pps requalified", lor[1], 0);
    run1 = 1'b0; wcyc(300);
    chk("R7 pps missing", lor[1], 1);
    hi1 = 4; lo1 = 4; defaults(1); run1 = 1'b1; wcyc(400);
    chk("R7 back to normal", lor[1], 0);
  endtask

  task automatic t_manual;
    man_en = 1'b1; man_use_pin = 1'b0; man_reg_sel = 1'b1; wcyc(5);
    chk("R10 register select", sel_idx, 1);
    man_use_pin = 1'b1; man_pin_sel = 1'b0; wcyc(5);
    chk("R10 pin select 0", sel_idx, 0);
    man_pin_sel = 1'b1; wcyc(5);
    chk("R10 pin select 1", sel_idx, 1);
    run1 = 1'b0; wcyc(40);
    chk("R10 fallback when chosen lost", sel_idx, 0);
    chk("R10 no holdover", holdover, 0);
    run1 = 1'b1; wcyc(400);
    chk("R10 manual choice restored", sel_idx, 1);
    man_en = 1'b0; wcyc(5);
    chk("R9 auto again", sel_idx, 0);
  endtask

  task automatic t_prio;
    cfg_prio = 1'b1; wcyc(5);
    chk("R9 prio 1", sel_idx, 1);
    cfg_prio = 1'b0; wcyc(5);
    chk("R9 prio 0", sel_idx, 0);
  endtask

  task automatic t_holdover;
    run1 = 1'b0; wcyc(40);
    chk("R11 one lost no holdover", holdover, 0);
    run0 = 1'b0; wcyc(40);
    chk("R11 holdover all lost", holdover, 1); chk("R11 sel held", sel_idx, 0);
    run0 = 1'b1; run1 = 1'b1; wcyc(400);
    chk("R11 holdover exit", holdover, 0); chk("R11 sel after exit", sel_idx, 0);
  endtask

  task automatic t_sticky;
    chk("R12 sticky set before clear", {st_sel, st_ho}, 3);
    sticky_clr = 1'b1; wcyc(1); sticky_clr = 1'b0; wcyc(1);
    chk("R12 sticky cleared", {st_sel, st_ho}, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    defaults(0); defaults(1);
    cfg_prio = 1'b0; man_en = 1'b0; man_use_pin = 1'b0;
    man_reg_sel = 1'b0; man_pin_sel = 1'b0; sticky_clr = 1'b0;
    t_reset();
    t_qualify();
    t_missing();
    t_early();
    t_runt();
    t_freq();
    t_disabled();
    t_pps();
    t_manual();
    t_prio();
    t_holdover();
    t_sticky();
    summary();
    $finish;
  end
endmodule